// File: doc/BRIEF.md
# Burst Column Address Generator

This block generates the column address for each beat of an SDRAM read or write burst. A start strobe captures a starting column, a burst-length code and a wrap type. From the next cycle on, the block presents one column per clock with a valid flag. It raises a last flag on the final beat of the burst.

Two beat orders are supported. In sequential order the column counts upward inside its aligned block. In interleaved order the low column bits are XORed with the beat number. A full-page burst covers the whole 256-entry column space. Full page is defined only for sequential order. A full-page request in interleaved order runs as sequential and raises an error flag for the duration of that burst.

A stop strobe ends a burst cleanly, so that no further valid beats follow. A new start strobe that arrives during a burst abandons the old burst and begins the new one on the next cycle. This lets a controller issue a random column on every clock.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, valid_o, last_o and err_o are 0.
- R2: When start_i is high at a clock edge, then in the following cycle valid_o is 1 and col_o equals the start_col_i sampled at that edge.
- R3: The length code len_code_i selects the number of beats. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Any code with bit 2 set gives a full page of 256 beats. last_o is 1 only on the final beat, and valid_o is 0 in the cycle after that beat unless a new start was taken.
- R4: With wrap_i = 0 (sequential), beat n of a burst of length L shows a column whose bits above log2(L) equal those of the start column. Its low log2(L) bits equal the start column's low bits plus n, modulo L.
- R5: With wrap_i = 1 (interleaved) and a code of 0 to 3, beat n shows a column whose bits above log2(L) equal those of the start column. Its low log2(L) bits equal the start column's low bits XOR n.
- R6: A full-page burst steps through the columns one by one and wraps from 255 to 0. It asserts last_o on beat 256.
- R7: A full-page code together with wrap_i = 1 runs in sequential order. In that case err_o is 1 on every valid beat of that burst, and err_o is 0 on every beat of any other burst.
- R8: When stop_i is high and start_i is low at a clock edge, valid_o and last_o are 0 from the next cycle until a new start.
- R9: A start strobe during a burst replaces the burst in progress, and the next cycle shows beat 0 of the new burst. When start_i and stop_i are high at the same edge, the start wins.
- R10: valid_o never rises unless start_i was high at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the parameters below |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code (0..3: 1/2/4/8 beats, bit 2 set: full page) |
| wrap_i | input | 1 | Beat order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the current burst |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | col_o holds a beat of an active burst |
| last_o | output | 1 | Current beat is the final beat |
| err_o | output | 1 | Current burst requested interleaved full page |

## Verification
The ordering logic is driven with start columns placed in the middle of their aligned blocks, so that a sequential count must wrap within the block. The same start column is then run in both wrap orders, which separates an add from an XOR on the low bits. Lengths 1, 2, 4 and 8 are each used with a start column whose upper bits are non-zero. This exposes any leak of a carry or a mask into the fixed bits. Two full-page bursts, one starting near the top of the column space, check the wrap from 255 to 0, the final beat at 256, and the error flag with its fallback to sequential order. Directed cases cover a stop in the middle of a burst, and a restart that collides with a stop in the same cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic {
    WRAP_SEQ   = 1'b0,
    WRAP_INTLV = 1'b1
  } wrap_e;

  localparam int LEN_CODE_W = 3;
  localparam int FULL_PAGE_BIT = 2;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  wrap_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  intlv_o,
  output logic                  err_o
);
  logic             full_page;
  logic [COL_W-1:0] one_hot;

  assign full_page = len_code_i[FULL_PAGE_BIT];
  assign one_hot   = {{(COL_W-1){1'b0}}, 1'b1} << len_code_i[1:0];

  always_comb begin
    if (full_page) mask_o = {COL_W{1'b1}};
    else           mask_o = one_hot - 1'b1;
  end

  // interleaved full page falls back to sequential
  assign intlv_o = (wrap_i == WRAP_INTLV) && !full_page;
  assign err_o   = (wrap_i == WRAP_INTLV) && full_page;

  always_comb begin
    if (!full_page) begin
      assert_mask_contig_R3: assert ((mask_o & (mask_o + 1'b1)) == '0);
    end
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;

  assign seq_col = base_i + beat_i;
  assign xor_col = base_i ^ beat_i;

  // bits outside the mask keep the start column
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (intlv_i ? xor_col[i] : seq_col[i]) : base_i[i];
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;

  assign last_o   = active_q && (beat_q == mask_i);
  assign active_o = active_q;
  assign beat_o   = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + 1'b1;
    end
  end

  assert_stop_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!active_o && !last_o));

  assert_last_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_o);

  assert_beat_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o && !start_i && !stop_i) |=> (active_o && beat_o == $past(beat_o) + 1'b1));
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  wrap_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_intlv;
  logic             dec_err;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             intlv_q;
  logic             err_q;

  logic             active;
  logic [COL_W-1:0] beat;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .wrap_i     (wrap_i),
    .mask_o     (dec_mask),
    .intlv_o    (dec_intlv),
    .err_o      (dec_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mask_q  <= '0;
      intlv_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      mask_q  <= dec_mask;
      intlv_q <= dec_intlv;
      err_q   <= dec_err;
    end
  end

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mask_i   (mask_q),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (last_o)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i  (base_q),
    .beat_i  (beat),
    .mask_i  (mask_q),
    .intlv_i (intlv_q),
    .col_o   (col_o)
  );

  assign valid_o = active;
  assign err_o   = active && err_q;

  assert_start_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_err_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);

  assert_upper_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (!valid_o || ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));

  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(start_i));

  assert_last_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {start col[11:4], len code[3:1], wrap[0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h35, 3'd1, 1'b0},
    {8'h35, 3'd2, 1'b0},
    {8'h3E, 3'd3, 1'b0},
    {8'h3E, 3'd3, 1'b1},
    {8'h35, 3'd2, 1'b1},
    {8'h9A, 3'd0, 1'b0},
    {8'hF0, 3'd4, 1'b0},
    {8'h10, 3'd7, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       wrap_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_col_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .wrap_i(wrap_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] b, logic [2:0] c, logic w, int n);
    logic [7:0] m;
    m = c[2] ? 8'hFF : 8'((1 << c[1:0]) - 1);
    if (w && !c[2]) return (b & ~m) | ((b ^ 8'(n)) & m);
    return (b & ~m) | ((b + 8'(n)) & m);
  endfunction

  function automatic int exp_len(logic [2:0] c);
    return c[2] ? 256 : (1 << c[1:0]);
  endfunction

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic launch(logic [7:0] c, logic [2:0] l, logic w);
    start_i = 1'b1; start_col_i = c; len_code_i = l; wrap_i = w;
    step();
    start_i = 1'b0;
  endtask

  task automatic run_burst(logic [7:0] c, logic [2:0] l, logic w);
    int len;
    len = exp_len(l);
    launch(c, l, w);
    for (int n = 0; n < len; n++) begin
      check(w && !l[2] ? "R5 col" : (l[2] ? "R6 col" : "R4 col"), col_o, exp_col(c, l, w, n));
      check("R2 valid", valid_o, 1);
      check("R3 last", last_o, (n == len - 1) ? 1 : 0);
      check("R7 err", err_o, (w && l[2]) ? 1 : 0);
      if (n < len - 1) step();
    end
    step();
    check("R3 valid after last", valid_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 valid in reset", valid_o, 0);
    check("R1 last in reset", last_o, 0);
    check("R1 err in reset", err_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    check("R1 valid after reset", valid_o, 0);
    check("R1 last after reset", last_o, 0);
    check("R1 err after reset", err_o, 0);
    step(); step();
    check("R10 idle valid", valid_o, 0);

    for (int v = 0; v < NVEC; v++)
      run_burst(VEC[v][11:4], VEC[v][3:1], VEC[v][0]);

    // R8: stop mid burst
    launch(8'h20, 3'd3, 1'b0);
    check("R8 beat0", col_o, 8'h20);
    step();
    check("R8 beat1", col_o, 8'h21);
    stop_i = 1'b1;
    step();
    stop_i = 1'b0;
    check("R8 valid after stop", valid_o, 0);
    check("R8 last after stop", last_o, 0);
    step(); step();
    check("R10 no resume after stop", valid_o, 0);

    // R9: restart mid burst, start beats stop in same cycle
    launch(8'h40, 3'd3, 1'b0);
    check("R9 old beat0", col_o, 8'h40);
    start_i = 1'b1; start_col_i = 8'h77; len_code_i = 3'd2; wrap_i = 1'b1; stop_i = 1'b1;
    step();
    start_i = 1'b0; stop_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      check("R9 new col", col_o, exp_col(8'h77, 3'd2, 1'b1, n));
      check("R9 new valid", valid_o, 1);
      check("R9 new last", last_o, (n == 3) ? 1 : 0);
      step();
    end
    check("R9 valid after new burst", valid_o, 0);

    // R7: err clears on next ordinary burst
    launch(8'h05, 3'd6, 1'b1);
    check("R7 err set", err_o, 1);
    launch(8'h05, 3'd1, 1'b1);
    check("R7 err cleared", err_o, 0);
    check("R5 col", col_o, 8'h05);
    step();
    check("R5 col beat1", col_o, 8'h04);
    check("R3 last len2", last_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule